// File: doc/BRIEF.md
# Operand-Dependent Early-Out Integer Divider

This block computes signed 32-bit integer quotients next to a pipelined multiply unit, on its own path so that multiply operations never wait for it. The time a divide takes follows the size of the dividend. A zero operand finishes almost at once. A dividend that fits in a byte or a halfword runs a shortened radix-2 iteration. Every other dividend runs the full 32 steps. The operand class is decided in the issue cycle and becomes a count in a down-counter, so each class has an exact and repeatable latency.

A second mode treats the 64-bit operand pair as two independent word divides, upper half and lower half. Both words run in lock-step and take the latency of the slower word's class. One divide may be in flight at a time. While `busy` is high, an issue request is not taken, and the issuer must keep presenting it. A result is delivered as a one-cycle strobe. A new divide may issue in that same strobe cycle.

Top module: `opdep_divider`

## Requirements
- R1: If the dividend or the divisor is zero, the quotient is 0 and `res_valid` rises exactly 4 cycles after the issue cycle.
- R2: A nonzero dividend in the range -128..127 with a nonzero divisor gives a latency of 11 cycles.
- R3: A nonzero dividend in the range -32768..32767 that is outside R2's range gives a latency of 19 cycles, and any other dividend gives 35 cycles. The divisor must be nonzero in both cases.
- R4: The quotient truncates toward zero. Its sign is the XOR of the operand signs.
- R5: The most negative dividend (0x80000000) divided by -1 gives 0x80000000.
- R6: When `issue_pair` is 0, only bits 31:0 of each operand are used, and `quotient[63:32]` reads 0 when the result is delivered.
- R7: When `issue_pair` is 1, `quotient[63:32]` is the quotient of bits 63:32 of the two operands, and `quotient[31:0]` is the quotient of bits 31:0.
- R8: In pair mode the latency is that of the slower word's class (R1 < R2 < R3 classes). The 4-cycle latency applies only when both words qualify for R1.
- R9: `busy` is high from the cycle after an accepted issue until the cycle before `res_valid`. While `busy` is high, `issue_valid` is ignored: it does not change the pending quotient and does not cause any extra result.
- R10: `res_valid` lasts exactly one cycle, and `quotient` holds the result during that cycle.
- R11: An issue presented in the cycle where `res_valid` is high is accepted. Its own latency is counted from that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | Divide request; accepted when `busy` is low |
| issue_pair | input | 1 | 1 = two independent word divides, 0 = scalar |
| dividend | input | 64 | Dividend; scalar mode uses bits 31:0 |
| divisor | input | 64 | Divisor; scalar mode uses bits 31:0 |
| busy | output | 1 | A divide is in flight; new requests wait |
| res_valid | output | 1 | One-cycle result strobe |
| quotient | output | 64 | Signed quotient(s), valid with `res_valid` |

## Verification
A result strobe and the acceptance of the next divide can fall in the same cycle. This is the only point where the counter is unloaded and reloaded on a single edge. The bench provokes it by holding the next request until it sees the strobe, then presenting it at once. It judges the old quotient in that cycle. It then measures the new divide's latency from that same cycle against its class. A request held across the whole busy window checks that a blocked issue neither disturbs the pending result nor produces a second strobe.

// File: rtl/opdep_div_pkg.sv
// Shared constants, latency classes and classification helpers for the
// operand-dependent divider. Assumes two's-complement word operands.
package opdep_div_pkg;
    localparam int WORD_W   = 32;
    localparam int LANES    = 2;
    localparam int NARROW_W = 8;
    localparam int MID_W    = 16;
    localparam int FIX_OVH  = 3;   // cycles of latency beyond the iterations
    localparam int CNT_W    = $clog2(WORD_W + FIX_OVH + 1);

    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_BYTE = 2'd1,
        CLS_HALF = 2'd2,
        CLS_FULL = 2'd3
    } lat_cls_t;

    // True when the word is a sign extension of its low n bits.
    function automatic logic fits_signed(input logic [WORD_W-1:0] v, input int n);
        logic all1;
        logic all0;
        all1 = 1'b1;
        all0 = 1'b1;
        for (int i = 0; i < WORD_W; i++) begin
            if (i >= n - 1) begin
                all1 = all1 & v[i];
                all0 = all0 & ~v[i];
            end
        end
        return all1 | all0;
    endfunction

    function automatic lat_cls_t classify(input logic [WORD_W-1:0] a,
                                          input logic [WORD_W-1:0] b);
        if (a == '0 || b == '0)           return CLS_ZERO;
        else if (fits_signed(a, NARROW_W)) return CLS_BYTE;
        else if (fits_signed(a, MID_W))    return CLS_HALF;
        else                               return CLS_FULL;
    endfunction

    // Radix-2 steps run for a class; latency is this plus FIX_OVH.
    function automatic logic [CNT_W-1:0] iter_count(input lat_cls_t c);
        case (c)
            CLS_ZERO: return CNT_W'(1);
            CLS_BYTE: return CNT_W'(NARROW_W);
            CLS_HALF: return CNT_W'(MID_W);
            default:  return CNT_W'(WORD_W);
        endcase
    endfunction
endpackage

// File: rtl/opdep_div_seq.sv
// Latency sequencer: one down-counter loaded at issue with latency-1.
// Drives busy, the one-cycle result strobe, and the step enable for the
// lanes. Assumes load_cnt >= FIX_OVH.
module opdep_div_seq
    import opdep_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [CNT_W-1:0] load_cnt,
    output logic             busy,
    output logic             res_valid,
    output logic             step
);
    logic             active;
    logic [CNT_W-1:0] cnt;

    // Count down the loaded latency; a new accept reloads it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (accept) begin
            active <= 1'b1;
            cnt    <= load_cnt;
        end else if (active) begin
            if (cnt == '0) active <= 1'b0;
            else           cnt    <= cnt - 1'b1;
        end
    end

    // Derive the handshake and iteration enable from the counter.
    always_comb begin
        res_valid = active && (cnt == '0);
        busy      = active && (cnt != '0);
        step      = active && (cnt >= CNT_W'(FIX_OVH));
    end

    // R10
    pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    // R9
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);
    // R9
    busy_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || res_valid));
endmodule

// File: rtl/opdep_div_lane.sv
// One word lane: restoring radix-2 divide on magnitudes, with the dividend
// pre-aligned so only 'iters' steps are needed. Sign restored at the output.
// Assumes |dividend| < 2**iters whenever the operands are nonzero.
module opdep_div_lane
    import opdep_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic [CNT_W-1:0]  iters,
    output logic [WORD_W-1:0] quot
);
    logic [WORD_W-1:0] rem, qacc, dmag;
    logic              neg, zero;
    logic [WORD_W-1:0] mag_a, mag_b;
    logic [CNT_W-1:0]  shamt;
    logic [WORD_W:0]   trial, diff;

    // Operand magnitudes, alignment shift and the trial subtraction.
    always_comb begin
        mag_a = op_a[WORD_W-1] ? -op_a : op_a;
        mag_b = op_b[WORD_W-1] ? -op_b : op_b;
        shamt = CNT_W'(WORD_W) - iters;
        trial = {rem, qacc[WORD_W-1]};
        diff  = trial - {1'b0, dmag};
    end

    // Load operands at issue, then one quotient bit per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem  <= '0;
            qacc <= '0;
            dmag <= '0;
            neg  <= 1'b0;
            zero <= 1'b1;
        end else if (load) begin
            rem  <= '0;
            qacc <= mag_a << shamt;
            dmag <= mag_b;
            neg  <= op_a[WORD_W-1] ^ op_b[WORD_W-1];
            zero <= (op_a == '0) || (op_b == '0);
        end else if (step) begin
            if (!diff[WORD_W]) begin
                rem  <= diff[WORD_W-1:0];
                qacc <= {qacc[WORD_W-2:0], 1'b1};
            end else begin
                rem  <= trial[WORD_W-1:0];
                qacc <= {qacc[WORD_W-2:0], 1'b0};
            end
        end
    end

    // Sign fixup and zero forcing on the finished magnitude.
    always_comb begin
        if (zero)     quot = '0;
        else if (neg) quot = -qacc;
        else          quot = qacc;
    end

    // R1
    zero_quot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && (op_a == '0 || op_b == '0)) |=> (quot == '0));
    // R10
    quot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(quot));
endmodule

// File: rtl/opdep_divider.sv
// Top of the operand-dependent divider: classifies operands at issue,
// picks the latency (slowest lane in pair mode), and runs the lanes in
// lock-step under the sequencer. Requests are taken only when not busy.
module opdep_divider
    import opdep_div_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    issue_valid,
    input  logic                    issue_pair,
    input  logic [LANES*WORD_W-1:0] dividend,
    input  logic [LANES*WORD_W-1:0] divisor,
    output logic                    busy,
    output logic                    res_valid,
    output logic [LANES*WORD_W-1:0] quotient
);
    logic                    accept, step, pair_q;
    lat_cls_t                cls_lo, cls_hi, cls_eff;
    logic [CNT_W-1:0]        iters, load_cnt;
    logic [LANES*WORD_W-1:0] lane_q;

    // Classify both words and select the governing class.
    always_comb begin
        accept   = issue_valid && !busy;
        cls_lo   = classify(dividend[WORD_W-1:0], divisor[WORD_W-1:0]);
        cls_hi   = classify(dividend[2*WORD_W-1:WORD_W], divisor[2*WORD_W-1:WORD_W]);
        cls_eff  = (issue_pair && (cls_hi > cls_lo)) ? cls_hi : cls_lo;
        iters    = iter_count(cls_eff);
        load_cnt = iters + CNT_W'(FIX_OVH - 1);
    end

    // Remember the mode of the divide in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)      pair_q <= 1'b0;
        else if (accept) pair_q <= issue_pair;
    end

    opdep_div_seq i_seq (
        .clk(clk), .rst_n(rst_n), .accept(accept), .load_cnt(load_cnt),
        .busy(busy), .res_valid(res_valid), .step(step)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        opdep_div_lane i_lane (
            .clk(clk), .rst_n(rst_n), .load(accept), .step(step),
            .op_a(dividend[g*WORD_W +: WORD_W]),
            .op_b(divisor[g*WORD_W +: WORD_W]),
            .iters(iters),
            .quot(lane_q[g*WORD_W +: WORD_W])
        );
    end

    // Upper word is meaningful only for a pair-mode divide.
    always_comb begin
        quotient = lane_q;
        if (!pair_q) quotient[LANES*WORD_W-1:WORD_W] = '0;
    end
endmodule

// File: tb/test_opdep_divider.sv
// Directed bench: one task per scenario, each checking its own results.
module test_opdep_divider;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic        issue_pair = 1'b0;
    logic [63:0] dividend = '0;
    logic [63:0] divisor = '0;
    logic        busy, res_valid;
    logic [63:0] quotient;
    int          checks = 0;
    int          errors = 0;

    always #(CLK_P/2) clk = ~clk;

    opdep_divider i_opdep_divider (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
        .issue_pair(issue_pair), .dividend(dividend), .divisor(divisor),
        .busy(busy), .res_valid(res_valid), .quotient(quotient)
    );

    task automatic chk(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_q(input logic [31:0] a, input logic [31:0] b);
        int sa, sb;
        sa = $signed(a);
        sb = $signed(b);
        if (b == 0) return 32'd0;
        if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return 32'h8000_0000;
        return 32'(sa / sb);
    endfunction

    function automatic int ref_cls(input logic [31:0] a, input logic [31:0] b);
        int sa;
        sa = $signed(a);
        if (a == 0 || b == 0) return 0;
        if (sa >= -128 && sa <= 127) return 1;
        if (sa >= -32768 && sa <= 32767) return 2;
        return 3;
    endfunction

    function automatic int cls_lat(input int c);
        case (c)
            0: return 4;
            1: return 11;
            2: return 19;
            default: return 35;
        endcase
    endfunction

    function automatic int exp_lat(input logic pair, input logic [63:0] a, input logic [63:0] b);
        int cl, ch;
        cl = ref_cls(a[31:0], b[31:0]);
        ch = ref_cls(a[63:32], b[63:32]);
        if (pair && ch > cl) cl = ch;
        return cls_lat(cl);
    endfunction

    function automatic logic [63:0] exp_q(input logic pair, input logic [63:0] a, input logic [63:0] b);
        return {pair ? ref_q(a[63:32], b[63:32]) : 32'd0, ref_q(a[31:0], b[31:0])};
    endfunction

    // Issue one divide, measure latency, check quotient and latency.
    task automatic do_div(input logic pair, input logic [63:0] a, input logic [63:0] b,
                          input string req);
        int k;
        while (busy) @(negedge clk);
        issue_valid = 1'b1;
        issue_pair  = pair;
        dividend    = a;
        divisor     = b;
        k = 0;
        do begin
            @(negedge clk);
            k++;
            if (k == 1) issue_valid = 1'b0;
        end while (!res_valid && k < 60);
        chk(k == exp_lat(pair, a, b), {req, " latency"}, 64'(k), 64'(exp_lat(pair, a, b)));
        chk(quotient == exp_q(pair, a, b), {req, " quotient"}, quotient, exp_q(pair, a, b));
        @(negedge clk);
        chk(!res_valid, "R10 strobe one cycle", 64'(res_valid), 64'd0);
    endtask

    task automatic t_reset;
        chk(!busy && !res_valid, "R9 reset idle", {62'd0, busy, res_valid}, 64'd0);
    endtask

    task automatic t_scalar;
        do_div(0, 64'd0, 64'd5, "R1 zero dividend");
        do_div(0, 64'd7, 64'd0, "R1 zero divisor");
        do_div(0, 64'd0, 64'd0, "R1 both zero");
        do_div(0, 64'd100, 64'd7, "R2 byte");
        do_div(0, {32'd0, 32'hFFFF_FF80}, 64'd3, "R2 byte min");
        do_div(0, 64'd127, {32'd0, 32'hFFFF_FFFE}, "R2 byte max");
        do_div(0, 64'd5, 64'd100000, "R2 small over large");
        do_div(0, {32'd0, 32'hFFFF_FF7F}, 64'd5, "R3 half edge");
        do_div(0, 64'd32767, 64'd10, "R3 half max");
        do_div(0, {32'd0, 32'hFFFF_8000}, 64'd7, "R3 half min");
        do_div(0, 64'd32768, 64'd3, "R3 full edge");
        do_div(0, 64'd123456789, {32'd0, 32'hFFFF_FC18}, "R3 full");
        do_div(0, {32'd0, 32'hFFFF_FFF9}, 64'd2, "R4 neg/pos");
        do_div(0, 64'd7, {32'd0, 32'hFFFF_FFFE}, "R4 pos/neg");
        do_div(0, {32'd0, 32'hFFFF_FFF9}, {32'd0, 32'hFFFF_FFFE}, "R4 neg/neg");
        do_div(0, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, "R5 min by -1");
        do_div(0, 64'h0000_0000_8000_0000, 64'd1, "R5 min by 1");
        do_div(0, 64'hDEAD_BEEF_0000_0064, 64'h1234_5678_0000_0009, "R6 upper ignored");
    endtask

    task automatic t_pair;
        do_div(1, 64'h0000_0000_0000_0000, 64'h0000_0003_0000_0000, "R8 both zero");
        do_div(1, 64'h0000_0000_0000_0064, 64'h0000_0005_0000_0007, "R8 zero+byte");
        do_div(1, 64'h0000_0050_0000_7000, 64'h0000_0003_0000_0009, "R8 byte+half");
        do_div(1, 64'h8000_0000_0000_0009, 64'hFFFF_FFFF_0000_0000, "R8 full+zero");
        do_div(1, 64'hFFFF_FFF9_0001_0000, 64'h0000_0002_FFFF_FFF0, "R7 lanes");
    endtask

    // Hold a second request through the whole busy window.
    task automatic t_busy;
        logic [63:0] a1, b1;
        int L, extra;
        a1 = 64'd1000000;
        b1 = 64'd13;
        L  = exp_lat(0, a1, b1);
        while (busy) @(negedge clk);
        issue_valid = 1'b1; issue_pair = 1'b0; dividend = a1; divisor = b1;
        for (int k = 1; k <= L; k++) begin
            @(negedge clk);
            if (k == 1) issue_valid = 1'b0;
            if (k == 2) begin
                issue_valid = 1'b1; dividend = 64'd55; divisor = 64'd5;
            end
            if (k == L - 2) issue_valid = 1'b0;
            if (k < L) begin
                chk(busy && !res_valid, "R9 busy window", {62'd0, busy, res_valid}, 64'd2);
            end else begin
                chk(!busy && res_valid, "R9 busy drops at result", {62'd0, busy, res_valid}, 64'd1);
                chk(quotient == exp_q(0, a1, b1), "R9 blocked issue no effect", quotient, exp_q(0, a1, b1));
            end
        end
        extra = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (res_valid) extra++;
        end
        chk(extra == 0, "R9 no extra result", 64'(extra), 64'd0);
    endtask

    // Next issue presented in the strobe cycle.
    task automatic t_back_to_back;
        logic [63:0] a1, b1, a2, b2;
        int k;
        a1 = 64'd90;  b1 = 64'd4;
        a2 = 64'd20000; b2 = {32'd0, 32'hFFFF_FFFD};
        while (busy) @(negedge clk);
        issue_valid = 1'b1; issue_pair = 1'b0; dividend = a1; divisor = b1;
        k = 0;
        do begin
            @(negedge clk);
            k++;
            if (k == 1) issue_valid = 1'b0;
        end while (!res_valid && k < 60);
        chk(k == 11, "R11 first latency", 64'(k), 64'd11);
        chk(quotient == exp_q(0, a1, b1), "R11 first quotient", quotient, exp_q(0, a1, b1));
        issue_valid = 1'b1; dividend = a2; divisor = b2;
        k = 0;
        do begin
            @(negedge clk);
            k++;
            if (k == 1) issue_valid = 1'b0;
        end while (!res_valid && k < 60);
        chk(k == exp_lat(0, a2, b2), "R11 second latency", 64'(k), 64'(exp_lat(0, a2, b2)));
        chk(quotient == exp_q(0, a2, b2), "R11 second quotient", quotient, exp_q(0, a2, b2));
    endtask

    function automatic logic [31:0] rnd_word();
        int unsigned w;
        logic [31:0] v;
        w = $urandom_range(1, 32);
        v = $urandom;
        if ($urandom_range(0, 9) == 0) return 32'd0;
        return 32'($signed(v << (32 - w)) >>> (32 - w));
    endfunction

    task automatic t_random;
        for (int i = 0; i < 60; i++) begin
            do_div(i[0], {rnd_word(), rnd_word()}, {rnd_word(), rnd_word()},
                   i[0] ? "R7 R8 random pair" : "R3 R4 random scalar");
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_scalar();
        t_pair();
        t_busy();
        t_back_to_back();
        t_random();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule